// File: doc/BRIEF.md
# I2C Master Write Engine with 7-bit and 10-bit Addressing

This block runs the bus-master side of I2C write transfers. A START request makes it issue a START condition and then send the address header built from the `slave_addr` and `mode_10b` inputs. In 10-bit mode the header is two bytes: a tag byte that carries the two high address bits, then the low eight bits. In 7-bit mode it is one byte. Payload bytes follow the header. They come from a one-entry holding register that is filled over a valid/ready stream port.

The holding register works as a double buffer. A byte is copied into the shift register when its first bit starts. The holding register is freed once that first bit's SCL high period ends, so the next byte can be queued while the current one is still shifting. Back-pressure rules for the stream port:
- `in_ready` is high exactly when the holding register is empty.
- A byte is taken on the clock edge where `in_valid` and `in_ready` are both high.
- The source must hold `in_data` steady while `in_valid` is high and `in_ready` is low.

Each ninth clock is an acknowledge slot. An acknowledge sets `ack_ok`. A not-acknowledge on any byte does all of the following:
- sets `nack_flag`;
- discards whatever is queued in the holding register;
- drops any pending START or STOP request;
- ends the transfer with a STOP.

If the holding register is empty at a byte boundary and no STOP is pending, SCL is held low until a byte arrives.

Both bus lines are open-drain. An `_oe` output at 1 pulls its line low. The quarter-bit period is the parameter `QUARTER`, in system clocks, with a default of 4.

Top module: `i2c10_master_tx`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `scl_oe`=0, `sda_oe`=0, `in_ready`=1, `ack_ok`=0, `nack_flag`=0.
- R2: With `mode_10b`=1 the first byte after START is binary 11110, then `slave_addr[9:8]`, then a 0 write bit. The second byte is `slave_addr[7:0]`. Payload bytes follow. Every byte is sent MSB first.
- R3: With `mode_10b`=0 the only header byte is `{slave_addr[6:0], 0}`, and payload bytes follow it directly.
- R4: A `start_req` pulse while `enable`=1 produces exactly one START, which is SDA falling while SCL is high. While `enable`=0 a `start_req` pulse has no effect, now or later.
- R5: `in_ready` is low while the holding register is full. A payload byte frees the register at the end of its first bit, which is after exactly one SCL rising edge of that byte.
- R6: `irq` equals `tx_ie & enable & in_ready`.
- R7: SDA low during the SCL high period of a ninth clock is an acknowledge and sets `ack_ok`=1.
- R8: A not-acknowledge of the first header byte sets `nack_flag`=1 and clears `ack_ok`. It discards the queued byte (`in_ready` returns to 1), sends no further byte, and issues a STOP.
- R9: A not-acknowledge of any later byte (the second header byte or a payload byte) sets `nack_flag` and ends the transfer with a STOP, dropping the queued byte.
- R10: A `stop_req` pulse during a transfer takes effect after the current byte and its acknowledge. SDA is pulled low, then released while SCL is high, and `busy` returns to 0.
- R11: At a byte boundary with an empty holding register and no pending STOP, SCL stays low, with no rising edge, until a byte is supplied.
- R12: Each SCL high and each SCL low period within a byte lasts 2·`QUARTER` clocks. Apart from START and STOP, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low forces idle and drops pending requests |
| mode_10b | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| slave_addr | input | 10 | Target address |
| start_req | input | 1 | One-cycle pulse requesting a START |
| stop_req | input | 1 | One-cycle pulse requesting a STOP after the current byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Holding register empty, byte can be taken |
| in_data | input | 8 | Payload byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transmit-empty interrupt |
| ack_ok | output | 1 | Last acknowledge slot saw an acknowledge |
| nack_flag | output | 1 | Sticky not-acknowledge, cleared by the next START |

## Verification
A corrupted header or shift register shows up within one byte time (9·4·`QUARTER` clocks) as a wrong byte in the slave model's record. A lost acknowledge decision shows up by the next byte boundary: either a transfer that keeps running after a not-acknowledge, or an early STOP. A holding register that is freed at the wrong moment changes the SCL edge count at which `in_ready` rises, or it lets a flushed byte reach the wire. A broken quarter-period sequence changes the measured SCL high and low widths at once. It also adds spurious START or STOP events, which the bench counts for every transfer.

// File: rtl/i2c10_pkg.sv
`timescale 1ns/1ps
package i2c10_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int ACK_SLOT = BYTE_W;
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT, ST_WAIT, ST_STOP
  } bus_st_t;

  typedef enum logic [1:0] {
    K_HDR1, K_HDR2, K_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c10_qtick.sv
`timescale 1ns/1ps
module i2c10_qtick #(
  parameter int QUARTER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || cnt == LAST) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  generate
    if (QUARTER > 1) begin : g_gap
      // R12
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/i2c10_txbuf.sv
`timescale 1ns/1ps
module i2c10_txbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         drain,
  input  logic         flush,
  output logic         full,
  output logic [W-1:0] dout
);
  logic take;
  assign in_ready = !full;
  assign take     = in_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else begin
      if (take) begin
        full <= 1'b1;
        dout <= in_data;
      end else if (drain || flush) begin
        full <= 1'b0;
      end
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !drain && !flush) |=> (full && $stable(dout)));
  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> full);
endmodule

// File: rtl/i2c10_seq.sv
`timescale 1ns/1ps
module i2c10_seq
  import i2c10_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_10b,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              tick,
  input  logic              buf_full,
  input  logic [BYTE_W-1:0] buf_data,
  input  logic              sda_in,
  output logic              drain,
  output logic              flush,
  output logic              run,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              ack_ok,
  output logic              nack_flag
);
  localparam logic [3:0] LAST_BIT = 4'(ACK_SLOT);

  bus_st_t           st;
  byte_kind_t        kind;
  logic [1:0]        ph;
  logic [3:0]        bitn;
  logic [BYTE_W-1:0] sh;
  logic              sda_lo, samp, start_pend, stop_pend;
  logic              end_q;
  logic [BYTE_W-1:0] hdr1;

  assign end_q = tick && (ph == 2'd3);
  assign hdr1  = mode_10b ? {TEN_BIT_TAG, slave_addr[9:8], 1'b0}
                          : {slave_addr[6:0], 1'b0};
  assign busy  = (st != ST_IDLE);
  assign run   = busy;
  assign drain = (st == ST_BIT) && (kind == K_DATA) && (bitn == 4'd0) && end_q;
  assign flush = (st == ST_BIT) && (bitn == LAST_BIT) && end_q && samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_HDR1; ph <= '0; bitn <= '0; sh <= '0;
      sda_lo <= 1'b0; samp <= 1'b1; start_pend <= 1'b0; stop_pend <= 1'b0;
      ack_ok <= 1'b0; nack_flag <= 1'b0;
    end else if (!enable) begin
      st <= ST_IDLE; ph <= '0; sda_lo <= 1'b0;
      start_pend <= 1'b0; stop_pend <= 1'b0;
    end else begin
      if (start_req) start_pend <= 1'b1;
      if (stop_req && busy) stop_pend <= 1'b1;
      case (st)
        ST_IDLE: if (start_pend) begin
          st <= ST_START; ph <= '0; start_pend <= 1'b0;
          ack_ok <= 1'b0; nack_flag <= 1'b0;
        end
        ST_START: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) begin
            sda_lo <= 1'b1; st <= ST_BIT; bitn <= '0; sh <= hdr1; kind <= K_HDR1;
          end
        end
        ST_BIT: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd0) sda_lo <= (bitn == LAST_BIT) ? 1'b0 : !sh[BYTE_W-1];
          if (ph == 2'd2) samp <= sda_in;
          if (ph == 2'd3) begin
            if (bitn != LAST_BIT) begin
              sh   <= {sh[BYTE_W-2:0], 1'b0};
              bitn <= bitn + 4'd1;
            end else begin
              bitn <= '0;
              if (samp) begin
                nack_flag <= 1'b1; ack_ok <= 1'b0;
                start_pend <= 1'b0; stop_pend <= 1'b0; st <= ST_STOP;
              end else begin
                ack_ok <= 1'b1;
                if (kind == K_HDR1 && mode_10b) begin
                  sh <= slave_addr[7:0]; kind <= K_HDR2;
                end else if (stop_pend) begin
                  stop_pend <= 1'b0; st <= ST_STOP;
                end else if (buf_full) begin
                  sh <= buf_data; kind <= K_DATA;
                end else begin
                  st <= ST_WAIT;
                end
              end
            end
          end
        end
        ST_WAIT: if (tick) begin
          if (stop_pend) begin
            stop_pend <= 1'b0; st <= ST_STOP; ph <= '0;
          end else if (buf_full) begin
            sh <= buf_data; kind <= K_DATA; st <= ST_BIT; bitn <= '0; ph <= '0;
          end
        end
        ST_STOP: if (tick) begin
          ph <= ph + 2'd1;
          if (ph == 2'd0) sda_lo <= 1'b1;
          if (ph == 2'd3) begin
            sda_lo <= 1'b0; st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_START: begin scl_oe = 1'b0;   sda_oe = ph[1];  end
      ST_BIT,
      ST_STOP:  begin scl_oe = !ph[1]; sda_oe = sda_lo; end
      ST_WAIT:  begin scl_oe = 1'b1;   sda_oe = sda_lo; end
      default:  begin scl_oe = 1'b0;   sda_oe = 1'b0;   end
    endcase
  end

  // R12
  sda_hi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
  // R8
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_flag) |-> (st == ST_STOP));
endmodule

// File: rtl/i2c10_master_tx.sv
`timescale 1ns/1ps
module i2c10_master_tx
  import i2c10_pkg::*;
#(
  parameter int QUARTER = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_10b,
  input  logic              tx_ie,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in,
  output logic              busy,
  output logic              irq,
  output logic              ack_ok,
  output logic              nack_flag
);
  logic              tick, run, drain, flush, buf_full;
  logic [BYTE_W-1:0] buf_data;

  i2c10_qtick #(.QUARTER(QUARTER)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  i2c10_txbuf #(.W(BYTE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .drain(drain), .flush(flush),
    .full(buf_full), .dout(buf_data)
  );

  i2c10_seq u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_10b(mode_10b),
    .slave_addr(slave_addr), .start_req(start_req), .stop_req(stop_req),
    .tick(tick), .buf_full(buf_full), .buf_data(buf_data), .sda_in(sda_in),
    .drain(drain), .flush(flush), .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .ack_ok(ack_ok), .nack_flag(nack_flag)
  );

  assign irq = tx_ie && enable && !buf_full;

  // R6
  irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> in_ready);
endmodule

// File: tb/tb_i2c10_master_tx.sv
`timescale 1ns/1ps
module tb_i2c10_master_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1, mode_10b = 1'b0, tx_ie = 1'b0;
  logic [9:0] slave_addr = '0;
  logic start_req = 1'b0, stop_req = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, scl_oe, sda_oe, busy, irq, ack_ok, nack_flag;
  logic slv_low = 1'b0;
  wire  scl_w = ~scl_oe;
  wire  sda_w = ~(sda_oe | slv_low);

  always #10 clk = ~clk;

  i2c10_master_tx dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_10b(mode_10b), .tx_ie(tx_ie),
    .slave_addr(slave_addr), .start_req(start_req), .stop_req(stop_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w),
    .busy(busy), .irq(irq), .ack_ok(ack_ok), .nack_flag(nack_flag)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural slave and bus monitors
  int bitc = 0, bcnt = 0, nack_at = -1, rx_n = 0;
  int starts = 0, stops = 0, rises = 0;
  int cyc = 0, t_rise = 0, t_fall = 0, hi_w = 0, lo_w = 0, rdy_bitc = -1;
  logic [7:0] sr = '0;
  logic [7:0] rxd [0:15];

  always @(posedge clk) cyc++;
  always @(negedge sda_w) if (scl_w) begin starts++; bitc = 0; bcnt = 0; end
  always @(posedge sda_w) if (scl_w) stops++;
  always @(posedge scl_w) begin
    rises++; lo_w = cyc - t_fall; t_rise = cyc;
    if (bitc < 8) sr = {sr[6:0], sda_w};
    bitc++;
  end
  always @(negedge scl_w) begin
    hi_w = cyc - t_rise; t_fall = cyc;
    if (bitc == 8) begin
      if (rx_n < 16) rxd[rx_n] = sr;
      rx_n++;
      slv_low = (bcnt != nack_at);
      bcnt++;
    end else if (bitc == 9) begin
      slv_low = 1'b0; bitc = 0;
    end
  end
  always @(posedge in_ready) if (busy) rdy_bitc = bitc;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); in_data = b; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1'b1; @(negedge clk); start_req = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic wait_empty();
    @(negedge clk); while (!in_ready) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk); while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  int st0, sp0;
  task automatic prep(input logic m10, input logic [9:0] a, input int nk);
    mode_10b = m10; slave_addr = a; nack_at = nk; rx_n = 0;
    st0 = starts; sp0 = stops;
  endtask

  task automatic test_reset();
    chk("R1 busy", busy, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 ack_ok", ack_ok, 0);
    chk("R1 nack_flag", nack_flag, 0);
  endtask

  task automatic test_ten_bit();
    prep(1'b1, 10'h2A5, -1);
    put_byte(8'h3C);
    pulse_start();
    put_byte(8'h81);
    put_byte(8'hFF);
    wait_empty();
    chk("R5 first-bit release", rdy_bitc, 1);
    pulse_stop();
    wait_idle();
    chk("R2 count", rx_n, 5);
    chk("R2 hdr1", rxd[0], 8'hF4);
    chk("R2 hdr2", rxd[1], 8'hA5);
    chk("R2 d0", rxd[2], 8'h3C);
    chk("R2 d1", rxd[3], 8'h81);
    chk("R2 d2", rxd[4], 8'hFF);
    chk("R7 ack_ok", ack_ok, 1);
    chk("R7 nack clear", nack_flag, 0);
    chk("R4 one start", starts - st0, 1);
    chk("R10 one stop", stops - sp0, 1);
    chk("R10 idle", busy, 0);
    chk("R12 scl high", hi_w, 8);
    chk("R12 scl low", lo_w, 8);
  endtask

  task automatic test_seven_bit();
    prep(1'b0, 10'h353, -1);
    put_byte(8'h5A);
    pulse_start();
    put_byte(8'hC3);
    wait_empty();
    pulse_stop();
    wait_idle();
    chk("R3 count", rx_n, 3);
    chk("R3 hdr", rxd[0], 8'hA6);
    chk("R3 d0", rxd[1], 8'h5A);
    chk("R3 d1", rxd[2], 8'hC3);
    chk("R12 start/stop", (starts - st0) * 16 + (stops - sp0), 8'h11);
  endtask

  task automatic test_nack_hdr1();
    prep(1'b1, 10'h1F0, 0);
    put_byte(8'h77);
    pulse_start();
    wait_idle();
    chk("R8 bytes", rx_n, 1);
    chk("R8 hdr1", rxd[0], 8'hF2);
    chk("R8 nack_flag", nack_flag, 1);
    chk("R8 ack_ok", ack_ok, 0);
    chk("R8 flushed", in_ready, 1);
    chk("R8 stop", stops - sp0, 1);
  endtask

  task automatic test_nack_hdr2();
    prep(1'b1, 10'h0CC, 1);
    put_byte(8'h11);
    pulse_start();
    wait_idle();
    chk("R9 bytes", rx_n, 2);
    chk("R9 hdr2", rxd[1], 8'hCC);
    chk("R9 nack_flag", nack_flag, 1);
    chk("R9 flushed", in_ready, 1);
    chk("R9 stop", stops - sp0, 1);
  endtask

  task automatic test_nack_data();
    prep(1'b0, 10'h021, 1);
    put_byte(8'h10);
    pulse_start();
    put_byte(8'h20);
    wait_idle();
    chk("R9 data bytes", rx_n, 2);
    chk("R9 hdr", rxd[0], 8'h42);
    chk("R9 data", rxd[1], 8'h10);
    chk("R9 data nack", nack_flag, 1);
    chk("R9 queued dropped", in_ready, 1);
  endtask

  task automatic test_hold_irq();
    int r0;
    prep(1'b0, 10'h005, -1);
    pulse_start();
    while (rx_n < 1) @(negedge clk);
    repeat (40) @(negedge clk);
    r0 = rises;
    repeat (300) @(negedge clk);
    chk("R11 no scl rise", rises, r0);
    chk("R11 scl low", scl_w, 0);
    chk("R11 busy", busy, 1);
    tx_ie = 1'b1;
    @(negedge clk);
    chk("R6 irq empty", irq, 1);
    put_byte(8'hE7);
    chk("R6 irq full", irq, 0);
    wait_empty();
    pulse_stop();
    wait_idle();
    tx_ie = 1'b0;
    chk("R11 bytes", rx_n, 2);
    chk("R11 data", rxd[1], 8'hE7);
  endtask

  task automatic test_disabled_start();
    int s0;
    s0 = starts;
    enable = 1'b0; tx_ie = 1'b1;
    @(negedge clk);
    chk("R6 irq disabled", irq, 0);
    pulse_start();
    repeat (50) @(negedge clk);
    enable = 1'b1;
    repeat (50) @(negedge clk);
    chk("R4 ignored busy", busy, 0);
    chk("R4 ignored start", starts, s0);
    tx_ie = 1'b0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_ten_bit();
    test_seven_bit();
    test_nack_hdr1();
    test_nack_hdr2();
    test_nack_data();
    test_hold_irq();
    test_disabled_start();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule